// File: doc/BRIEF.md
# Capture Timer, 16-bit

This block is a 16-bit up-counter for timing events on a pin. It counts either ticks of the system clock, divided by 12 or by 4, or falling edges on an external count pin. A falling edge on a separate capture pin copies the running count into a capture register and raises a sticky capture flag. When the count wraps from FFFFh to 0000h, a second sticky flag is raised. Each flag drives its own interrupt output.

An optional auto-clear setting returns the counter to zero as soon as a capture has been taken. With auto-clear on, each captured value is the interval since the previous capture edge, and software never has to restart the counter. Both pins pass through a two-flop synchroniser before their falling edges are detected. Software reads and writes the block through a small byte-wide register port.

Top module: `cap_timer16`

## Requirements
- R1: After reset, every register reads 0, both flags are clear and both interrupt outputs are low.
- R2: The register map is fixed. Address 0 is control: bit0 run, bit1 external source, bit2 fast divide, bit3 capture enable, bit4 auto-clear, bit5 reads 0, bit6 capture flag, bit7 overflow flag. Addresses 1 and 2 are the count low and high bytes, readable and writable. Addresses 3 and 4 are the capture low and high bytes, read-only. Any other address reads 0.
- R3: With run set and the external source clear, the counter advances once every 12 clocks, or once every 4 clocks when fast divide is set. The divider restarts from zero whenever run is clear, so after run has been set for N clock edges the count has grown by floor(N/divisor).
- R4: With run set and the external source set, the counter advances once for each falling edge on cnt_pin. Each edge takes effect three clock edges after the pin falls.
- R5: While run is clear, neither the divider nor cnt_pin changes the counter.
- R6: An increment from FFFFh to 0000h sets the overflow flag, and ovf_irq equals that flag.
- R7: With capture enable set, a falling edge on cap_pin copies the counter into the capture register and sets the capture flag; cap_irq equals that flag. A capture happens whether or not run is set.
- R8: With capture enable clear, cap_pin changes neither the capture register nor the capture flag.
- R9: With auto-clear set, the counter reads 0 right after a capture.
- R10: When a capture and an increment fall in the same cycle, the captured value is the count before the increment. If auto-clear is set, the clear wins over the increment.
- R11: Both flags stay set until software writes 0 to them. Writing 1 to a flag sets it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| reg_addr | input | 3 | Register address |
| reg_wr | input | 1 | Write strobe for the addressed register |
| reg_wdata | input | 8 | Write data |
| reg_rdata | output | 8 | Read data for reg_addr (combinational) |
| cnt_pin | input | 1 | External count input; counts on falling edges |
| cap_pin | input | 1 | Capture trigger; acts on falling edges |
| ovf_irq | output | 1 | Overflow interrupt (overflow flag) |
| cap_irq | output | 1 | Capture interrupt (capture flag) |

## Verification
The bench drives a capture edge and a count edge in the same clock cycle, both with auto-clear on and with it off. A design that samples the count after the increment would capture one too many, and one that lets the increment beat the clear would leave the counter at 1. A preset count of FFFEh is stepped across the wrap: a missing overflow flag, or a carry into the high byte that stays set, shows up in the control and count readbacks. Counting is also timed at both divide ratios from a divider restarted by run. A divider that keeps its phase across a stop, or that uses the wrong terminal value, gives a count that differs from floor(N/divisor). Finally, edges are applied with run clear and with capture enable clear, and the counter, the capture register and the flags are read to confirm that nothing changed.

// File: rtl/cap_timer16_pkg.sv
// Package: shared constants for the capture timer.
// Assumes an 8-bit register port; the control bit positions are fixed here.
package cap_timer16_pkg;
    localparam int CTL_RUN  = 0;
    localparam int CTL_EXT  = 1;
    localparam int CTL_FAST = 2;
    localparam int CTL_CEN  = 3;
    localparam int CTL_ACLR = 4;
    localparam int CTL_CFLG = 6;
    localparam int CTL_OFLG = 7;

    // Snapshot of the control settings.
    typedef struct packed {
        logic run;
        logic ext;
        logic fast;
        logic cen;
        logic aclr;
    } ctl_t;
endpackage

// File: rtl/cap_timer16_sync.sv
// Synchroniser and falling-edge detector for one asynchronous pin.
// Assumes the pin idles high; every stage resets to 1, so reset produces no false edge.
module cap_timer16_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic pin,
    output logic fall
);
    localparam int LAST = STAGES;

    logic [LAST:0] sh_q;

    // Shift the pin through the sync stages plus one history stage.
    always_ff @(posedge clk) begin
        if (!rst_n) sh_q <= '1;
        else        sh_q <= {sh_q[LAST-1:0], pin};
    end

    // A falling edge shows as old-high, new-low at the synchronised output.
    assign fall = sh_q[LAST] & ~sh_q[LAST-1];
endmodule

// File: rtl/cap_timer16_presc.sv
// Clock prescaler that produces a one-cycle tick every DIV_SLOW or DIV_FAST clocks.
// Assumes DIV_FAST <= DIV_SLOW; the phase counter is held at zero while en is low.
module cap_timer16_presc #(
    parameter int DIV_SLOW = 12,
    parameter int DIV_FAST = 4
) (
    input  logic clk,
    input  logic rst_n,
    input  logic en,
    input  logic fast,
    output logic tick
);
    localparam int PW = $clog2(DIV_SLOW);
    localparam logic [PW-1:0] LIM_S = PW'(DIV_SLOW - 1);
    localparam logic [PW-1:0] LIM_F = PW'(DIV_FAST - 1);

    logic [PW-1:0] ph_q;
    logic [PW-1:0] lim;

    // Select the terminal phase for the chosen ratio.
    assign lim  = fast ? LIM_F : LIM_S;
    assign tick = en && (ph_q >= lim);

    // Phase counter: wraps on a tick and restarts while disabled.
    always_ff @(posedge clk) begin
        if (!rst_n || !en) ph_q <= '0;
        else if (tick)     ph_q <= '0;
        else               ph_q <= ph_q + 1'b1;
    end
endmodule

// File: rtl/cap_timer16_core.sv
// Counter and capture register datapath.
// Assumes at most one lane write per cycle. Precedence: software byte write,
// then auto-clear on capture, then increment. A capture takes the pre-update count.
module cap_timer16_core #(
    parameter int CNT_W  = 16,
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              inc,
    input  logic              cap_fire,
    input  logic              auto_clr,
    input  logic [CNT_W/DATA_W-1:0] lane_wr,
    input  logic [DATA_W-1:0] wr_data,
    output logic [CNT_W-1:0]  count,
    output logic [CNT_W-1:0]  capt,
    output logic              ovf_evt
);
    localparam int NB = CNT_W / DATA_W;

    logic [CNT_W-1:0] nxt;

    // Next count from the precedence of write, clear and increment.
    always_comb begin
        nxt     = count;
        ovf_evt = 1'b0;
        if (|lane_wr) begin
            for (int i = 0; i < NB; i++) begin
                if (lane_wr[i]) nxt[i*DATA_W +: DATA_W] = wr_data;
            end
        end else if (cap_fire && auto_clr) begin
            nxt = '0;
        end else if (inc) begin
            nxt     = count + 1'b1;
            ovf_evt = &count;
        end
    end

    // Count register.
    always_ff @(posedge clk) begin
        if (!rst_n) count <= '0;
        else        count <= nxt;
    end

    // Capture register, loaded with the count as it stood before this cycle's update.
    always_ff @(posedge clk) begin
        if (!rst_n)        capt <= '0;
        else if (cap_fire) capt <= count;
    end
endmodule

// File: rtl/cap_timer16.sv
// Top level of the 16-bit capture timer: register port, control, flags and read mux.
// Assumes a byte-wide port with a combinational read and a single-cycle write strobe.
module cap_timer16
    import cap_timer16_pkg::*;
#(
    parameter int CNT_W    = 16,
    parameter int DATA_W   = 8,
    parameter int DIV_SLOW = 12,
    parameter int DIV_FAST = 4,
    parameter int SYNC_N   = 2,
    parameter int ADDR_W   = $clog2(2 * (CNT_W / DATA_W) + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] reg_addr,
    input  logic              reg_wr,
    input  logic [DATA_W-1:0] reg_wdata,
    output logic [DATA_W-1:0] reg_rdata,
    input  logic              cnt_pin,
    input  logic              cap_pin,
    output logic              ovf_irq,
    output logic              cap_irq
);
    localparam int NB = CNT_W / DATA_W;

    ctl_t             ctl_q;
    logic             cap_flag_q;
    logic             ovf_flag_q;
    logic             wr_ctrl;
    logic [NB-1:0]    lane_wr;
    logic             cnt_fall;
    logic             cap_fall;
    logic             pre_tick;
    logic             inc;
    logic             cap_fire;
    logic             ovf_evt;
    logic [CNT_W-1:0] count_q;
    logic [CNT_W-1:0] capt_q;

    // Decode the writes to the control register and the count lanes.
    assign wr_ctrl = reg_wr && (reg_addr == '0);
    for (genvar i = 0; i < NB; i++) begin : g_lane
        assign lane_wr[i] = reg_wr && (reg_addr == ADDR_W'(1 + i));
    end

    cap_timer16_sync #(.STAGES(SYNC_N)) u_cnt_sync (
        .clk(clk), .rst_n(rst_n), .pin(cnt_pin), .fall(cnt_fall)
    );

    cap_timer16_sync #(.STAGES(SYNC_N)) u_cap_sync (
        .clk(clk), .rst_n(rst_n), .pin(cap_pin), .fall(cap_fall)
    );

    cap_timer16_presc #(.DIV_SLOW(DIV_SLOW), .DIV_FAST(DIV_FAST)) u_presc (
        .clk(clk), .rst_n(rst_n), .en(ctl_q.run && !ctl_q.ext),
        .fast(ctl_q.fast), .tick(pre_tick)
    );

    // Count enable from the selected source, and the gated capture request.
    assign inc      = ctl_q.run && (ctl_q.ext ? cnt_fall : pre_tick);
    assign cap_fire = ctl_q.cen && cap_fall;

    cap_timer16_core #(.CNT_W(CNT_W), .DATA_W(DATA_W)) u_core (
        .clk(clk), .rst_n(rst_n), .inc(inc), .cap_fire(cap_fire),
        .auto_clr(ctl_q.aclr), .lane_wr(lane_wr), .wr_data(reg_wdata),
        .count(count_q), .capt(capt_q), .ovf_evt(ovf_evt)
    );

    // Control settings register.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ctl_q <= '0;
        end else if (wr_ctrl) begin
            ctl_q.run  <= reg_wdata[CTL_RUN];
            ctl_q.ext  <= reg_wdata[CTL_EXT];
            ctl_q.fast <= reg_wdata[CTL_FAST];
            ctl_q.cen  <= reg_wdata[CTL_CEN];
            ctl_q.aclr <= reg_wdata[CTL_ACLR];
        end
    end

    // Sticky flags: a hardware event sets the flag, otherwise a software write loads it.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cap_flag_q <= 1'b0;
            ovf_flag_q <= 1'b0;
        end else begin
            if (cap_fire)     cap_flag_q <= 1'b1;
            else if (wr_ctrl) cap_flag_q <= reg_wdata[CTL_CFLG];
            if (ovf_evt)      ovf_flag_q <= 1'b1;
            else if (wr_ctrl) ovf_flag_q <= reg_wdata[CTL_OFLG];
        end
    end

    assign ovf_irq = ovf_flag_q;
    assign cap_irq = cap_flag_q;

    // Read mux over the control, count and capture registers.
    always_comb begin
        reg_rdata = '0;
        if (reg_addr == '0) begin
            reg_rdata[CTL_RUN]  = ctl_q.run;
            reg_rdata[CTL_EXT]  = ctl_q.ext;
            reg_rdata[CTL_FAST] = ctl_q.fast;
            reg_rdata[CTL_CEN]  = ctl_q.cen;
            reg_rdata[CTL_ACLR] = ctl_q.aclr;
            reg_rdata[CTL_CFLG] = cap_flag_q;
            reg_rdata[CTL_OFLG] = ovf_flag_q;
        end
        for (int i = 0; i < NB; i++) begin
            if (reg_addr == ADDR_W'(1 + i))      reg_rdata = count_q[i*DATA_W +: DATA_W];
            if (reg_addr == ADDR_W'(1 + NB + i)) reg_rdata = capt_q[i*DATA_W +: DATA_W];
        end
    end
endmodule

// File: rtl/cap_timer16_chk.sv
// Checker for the capture timer: properties over its internal state, attached by bind.
// Assumes the signal names of cap_timer16.
module cap_timer16_chk #(
    parameter int CNT_W = 16,
    parameter int NB    = 2
) (
    input logic             clk,
    input logic             rst_n,
    input logic             run,
    input logic             cen,
    input logic             aclr,
    input logic             inc,
    input logic             cap_fire,
    input logic             wr_ctrl,
    input logic [NB-1:0]    lane_wr,
    input logic [CNT_W-1:0] count_q,
    input logic [CNT_W-1:0] capt_q,
    input logic             cap_flag_q,
    input logic             ovf_flag_q
);
    // R5: with run clear and no clear or write, the count holds.
    p_stop_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (!run && lane_wr == '0 && !(cap_fire && aclr)) |=> $stable(count_q));

    // R6: a wrap from all-ones raises the overflow flag.
    p_wrap_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (inc && &count_q && lane_wr == '0 && !(cap_fire && aclr)) |=> ovf_flag_q);

    // R7 and R10: a capture stores the pre-update count and sets the flag.
    p_capt_r7: assert property (@(posedge clk) disable iff (!rst_n)
        cap_fire |=> (cap_flag_q && capt_q == $past(count_q)));

    // R8: with capture disabled the capture register holds.
    p_ign_r8: assert property (@(posedge clk) disable iff (!rst_n)
        !cen |=> $stable(capt_q));

    // R9: auto-clear leaves the count at zero.
    p_clr_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (cap_fire && aclr && lane_wr == '0) |=> count_q == '0);

    // R11: without a control write both flags stay set.
    p_hold_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (ovf_flag_q && cap_flag_q && !wr_ctrl) |=> (ovf_flag_q && cap_flag_q));
endmodule

bind cap_timer16 cap_timer16_chk #(.CNT_W(CNT_W), .NB(NB)) u_chk (
    .clk(clk), .rst_n(rst_n), .run(ctl_q.run), .cen(ctl_q.cen), .aclr(ctl_q.aclr),
    .inc(inc), .cap_fire(cap_fire), .wr_ctrl(wr_ctrl), .lane_wr(lane_wr),
    .count_q(count_q), .capt_q(capt_q), .cap_flag_q(cap_flag_q), .ovf_flag_q(ovf_flag_q)
);

// File: tb/cap_timer16_tb.sv
// Scoreboard bench: the driver queues expected readbacks, the monitor compares them.
module cap_timer16_tb;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [2:0] reg_addr = '0;
    logic       reg_wr = 1'b0;
    logic [7:0] reg_wdata = '0;
    logic [7:0] reg_rdata;
    logic       cnt_pin = 1'b1;
    logic       cap_pin = 1'b1;
    logic       ovf_irq;
    logic       cap_irq;

    int vectors = 0;
    int fails   = 0;
    bit done    = 1'b0;

    typedef struct {
        int         sel;   // 0..7 register address, 8 = {ovf_irq, cap_irq}
        logic [7:0] exp;
        string      tag;
    } item_t;
    item_t exp_q[$];
    event  mon_ev;

    localparam logic [7:0] RUN = 8'h01, EXT = 8'h02, FST = 8'h04, CEN = 8'h08,
                           ACL = 8'h10, CFL = 8'h40, OFL = 8'h80;

    always #4 clk = ~clk;

    cap_timer16 u_dut (
        .clk(clk), .rst_n(rst_n), .reg_addr(reg_addr), .reg_wr(reg_wr),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .cnt_pin(cnt_pin),
        .cap_pin(cap_pin), .ovf_irq(ovf_irq), .cap_irq(cap_irq)
    );

    // Monitor: pops one expected item per request and compares it.
    initial begin
        forever begin
            item_t it;
            logic [7:0] act;
            @(mon_ev);
            it = exp_q.pop_front();
            act = (it.sel == 8) ? {6'b0, ovf_irq, cap_irq} : reg_rdata;
            vectors++;
            if (act !== it.exp) begin
                fails++;
                $display("FAIL %s: sel %0d actual %h expected %h", it.tag, it.sel, act, it.exp);
            end
        end
    end

    // Tasks all start and end at a falling edge.
    task automatic wr(input logic [2:0] a, input logic [7:0] d);
        reg_addr = a; reg_wdata = d; reg_wr = 1'b1;
        @(negedge clk);
        reg_wr = 1'b0;
    endtask

    task automatic chk(input int sel, input logic [7:0] e, input string tag);
        item_t it;
        it.sel = sel; it.exp = e; it.tag = tag;
        if (sel < 8) reg_addr = 3'(sel);
        exp_q.push_back(it);
        #1 ->mon_ev;
        @(negedge clk);
    endtask

    task automatic pulse_cnt(input int n);
        for (int k = 0; k < n; k++) begin
            cnt_pin = 1'b0; repeat (3) @(negedge clk);
            cnt_pin = 1'b1; repeat (3) @(negedge clk);
        end
    endtask

    task automatic pulse_cap();
        cap_pin = 1'b0; repeat (3) @(negedge clk);
        cap_pin = 1'b1; repeat (3) @(negedge clk);
    endtask

    task automatic pulse_both();
        cap_pin = 1'b0; cnt_pin = 1'b0; repeat (3) @(negedge clk);
        cap_pin = 1'b1; cnt_pin = 1'b1; repeat (3) @(negedge clk);
    endtask

    task automatic set_count(input logic [15:0] v);
        wr(3'd1, v[7:0]);
        wr(3'd2, v[15:8]);
    endtask

    task automatic chk_count(input logic [15:0] v, input string tag);
        chk(1, v[7:0], tag);
        chk(2, v[15:8], tag);
    endtask

    // Run the prescaled source for g+1 edges, then stop and check floor((g+1)/div).
    task automatic timed_run(input logic [7:0] mode, input int g, input int div);
        set_count(16'h0000);
        wr(3'd0, RUN | mode);
        repeat (g) @(negedge clk);
        wr(3'd0, mode);
        chk_count(16'((g + 1) / div), "R3 prescaled count");
    endtask

    // Watchdog: a hung run counts as a failure and still reports.
    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            fails++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1: reset state
        chk(0, 8'h00, "R1 ctrl after reset");
        chk_count(16'h0000, "R1 count after reset");
        chk(3, 8'h00, "R1 capture lo after reset");
        chk(4, 8'h00, "R1 capture hi after reset");
        chk(8, 8'h00, "R1 irq pins after reset");

        // R2: map and count write/read, unused address, bit5
        set_count(16'h1234);
        chk_count(16'h1234, "R2 count readback");
        chk(7, 8'h00, "R2 unused address");
        wr(3'd3, 8'h5A);
        chk(3, 8'h00, "R2 capture read-only");
        wr(3'd0, EXT | 8'h20);
        chk(0, EXT, "R2 bit5 reads zero");

        // R5: external edges ignored while stopped
        pulse_cnt(3);
        chk_count(16'h1234, "R5 no count while stopped");

        // R4: external counting
        wr(3'd0, RUN | EXT);
        pulse_cnt(5);
        chk_count(16'h1239, "R4 external count");

        // R3: prescaled at both ratios
        wr(3'd0, 8'h00);
        timed_run(FST, 39, 4);
        timed_run(8'h00, 47, 12);
        timed_run(FST, 21, 4);
        timed_run(8'h00, 30, 12);

        // R5: prescaler stopped
        set_count(16'h0042);
        repeat (30) @(negedge clk);
        chk_count(16'h0042, "R5 no prescaled count while stopped");

        // R6: overflow
        set_count(16'hFFFE);
        wr(3'd0, RUN | EXT);
        pulse_cnt(1);
        chk(0, RUN | EXT, "R6 no flag before wrap");
        pulse_cnt(1);
        chk_count(16'h0000, "R6 wrapped count");
        chk(0, RUN | EXT | OFL, "R6 overflow flag");
        chk(8, 8'h02, "R6 ovf_irq");

        // R11: clear by writing 0, set by writing 1
        pulse_cnt(1);
        chk(0, RUN | EXT | OFL, "R11 flag sticky");
        wr(3'd0, RUN | EXT);
        chk(8, 8'h00, "R11 flag cleared by write");
        wr(3'd0, RUN | EXT | CFL);
        chk(8, 8'h01, "R11 flag set by write");
        wr(3'd0, RUN | EXT);

        // R7: capture
        set_count(16'h0000);
        wr(3'd0, RUN | EXT | CEN);
        pulse_cnt(7);
        pulse_cap();
        chk(3, 8'h07, "R7 capture lo");
        chk(4, 8'h00, "R7 capture hi");
        chk(0, RUN | EXT | CEN | CFL, "R7 capture flag");
        chk(8, 8'h01, "R7 cap_irq");
        chk_count(16'h0007, "R7 count kept");
        pulse_cnt(2);
        chk(0, RUN | EXT | CEN | CFL, "R11 capture flag sticky");

        // R8: capture disabled
        wr(3'd0, RUN | EXT);
        pulse_cap();
        chk(3, 8'h07, "R8 capture unchanged");
        chk(0, RUN | EXT, "R8 flag stays clear");

        // R9: auto-clear
        wr(3'd0, RUN | EXT | CEN | ACL);
        pulse_cnt(3);
        pulse_cap();
        chk(3, 8'h0C, "R9 captured interval");
        chk_count(16'h0000, "R9 count cleared");
        pulse_cnt(4);
        pulse_cap();
        chk(3, 8'h04, "R9 second interval");

        // R10: simultaneous capture and increment
        pulse_cnt(4);
        pulse_both();
        chk(3, 8'h04, "R10 pre-increment capture (auto-clear)");
        chk_count(16'h0000, "R10 clear beats increment");
        wr(3'd0, RUN | EXT | CEN);
        pulse_cnt(6);
        pulse_both();
        chk(3, 8'h06, "R10 pre-increment capture");
        chk_count(16'h0007, "R10 increment kept without auto-clear");

        // R7: capture while stopped
        wr(3'd0, CEN);
        set_count(16'hABCD);
        pulse_cap();
        chk(3, 8'hCD, "R7 capture lo while stopped");
        chk(4, 8'hAB, "R7 capture hi while stopped");

        repeat (2) @(negedge clk);
        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
        $finish;
    end
endmodule